// File: doc/BRIEF.md
# Triangular-Window Averaging Filter

This block smooths a stream of signed sensor samples. Each sample arrives with a one-cycle strobe. The block applies a triangular-weighted FIR filter and returns the result one clock later with a valid flag. The filter is two equal boxcar running-sum averagers in series, each of length N = 2^M. The combined impulse response is a triangle spanning 2N-1 samples, and the magnitude response is a squared sinc. All normalization uses arithmetic right shifts by M, so the block contains no divider and no coefficient storage.

The only configuration is the 3-bit length select. Any change to it discards the filter history. The output flag stays low until a full triangular window of fresh samples has been seen.

Top module: `tri_window_filter`

## Requirements
- R1: While reset is asserted and right after it, `filtOut` is 0 and `filtValid` is 0.
- R2: The window length is N = 2^lenSel for lenSel 0..7. For example, an impulse at lenSel = 3 produces exactly 15 nonzero outputs shaped as a triangle.
- R3: Let k count the samples accepted since the last clear, with earlier samples counted as zero. The stage value is a(k) = floor(sum of x(k-j) for j=0..N-1, divided by N). The output is y(k) = floor(sum of a(k-j) for j=0..N-1, divided by N). y(k) appears on `filtOut` in the cycle after the accepting edge, and it is updated for every accepted sample, including during warm-up.
- R4: `filtValid` is high for one cycle after an accepted sample only when that sample is at least the (2N-1)-th since the last clear.
- R5: A clock edge at which `lenSel` differs from the length currently in use clears the history and drives `filtOut` to 0 and `filtValid` to 0. A sample strobed at that same edge is discarded.
- R6: With lenSel = 0, each sample appears unchanged on `filtOut` one cycle later, and `filtValid` is high for every sample.
- R7: At lenSel = 7, a constant full-scale input (+32767 or -32768 at 16 bits) is reproduced exactly, with no accumulator overflow.
- R8: In cycles without an accepted sample and without a clear, `filtOut` holds its value and `filtValid` is 0.
- R9: Both normalizations truncate toward minus infinity. For example, a single -1 at lenSel = 1 yields an output of -1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe: sampleIn is a new sample |
| sampleIn | input | DATA_W (16) | Signed input sample |
| lenSel | input | 3 | Window length exponent M, N = 2^M |
| filtOut | output | DATA_W (16) | Signed filtered value |
| filtValid | output | 1 | Pulses when filtOut holds a full-window result |

## Verification
The assertions assume that `lenSel` never exceeds the largest configured exponent. They also assume that inputs are stable around the clock edge, so the overflow check on the running sums can rely on the delay-line tap being taken only after N fresh samples have entered. The stimulus drives every input on the falling edge, keeps `lenSel` within 0..7, and changes it only between bursts or deliberately together with a strobe to exercise the discard case. The running sums are checked against full-scale constants at the longest window, which is the worst case for accumulator growth.

// File: rtl/trif_pkg.sv
package trif_pkg;
  // Strobes from control to datapath, one set per clock.
  typedef struct packed {
    logic clear;     // discard history
    logic accept;    // take sampleIn this cycle
    logic subtract;  // delay-line tap holds a fresh sample
    logic emit;      // result completes a full window
  } trifStrobe_t;
endpackage

// File: rtl/trif_boxcar.sv
module trif_boxcar
  import trif_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_M  = 7,
  parameter int M_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  trifStrobe_t              strobe,
  input  logic [M_W-1:0]           shiftM,
  input  logic signed [DATA_W-1:0] dIn,
  output logic signed [DATA_W-1:0] avgOut
);
  localparam int DEPTH = 1 << MAX_M;
  localparam int ACC_W = DATA_W + MAX_M;

  logic signed [DATA_W-1:0] taps [DEPTH];
  logic signed [ACC_W-1:0]  runSum;
  logic signed [DATA_W-1:0] oldest;
  logic signed [ACC_W:0]    sumNext;
  logic signed [ACC_W:0]    scaled;
  logic [MAX_M-1:0]         tapIdx;

  always_comb begin
    tapIdx  = MAX_M'((32'd1 << shiftM) - 32'd1);
    oldest  = strobe.subtract ? taps[tapIdx] : '0;
    sumNext = (ACC_W+1)'(runSum) + (ACC_W+1)'(dIn) - (ACC_W+1)'(oldest);
    scaled  = sumNext >>> shiftM;
    avgOut  = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear) runSum <= '0;
    else if (strobe.accept)     runSum <= sumNext[ACC_W-1:0];
  end

  // Delay line needs no clearing: the tap is gated until N fresh samples exist.
  always_ff @(posedge clk) begin
    if (strobe.accept) begin
      taps[0] <= dIn;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.accept |-> (sumNext[ACC_W] == sumNext[ACC_W-1]));
endmodule

// File: rtl/trif_ctrl.sv
module trif_ctrl
  import trif_pkg::*;
#(
  parameter int MAX_M = 7,
  parameter int M_W   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sampleValid,
  input  logic [M_W-1:0] lenSel,
  output trifStrobe_t    strobe,
  output logic [M_W-1:0] curM
);
  localparam int CNT_W = MAX_M + 1;

  logic [CNT_W-1:0] fillCnt;
  logic [31:0]      lenN;
  logic [31:0]      fullCnt;

  always_comb begin
    lenN            = 32'd1 << curM;
    fullCnt         = (lenN << 1) - 32'd1;
    strobe.clear    = (lenSel != curM);
    strobe.accept   = sampleValid && !strobe.clear;
    strobe.subtract = (32'(fillCnt) >= lenN);
    strobe.emit     = strobe.accept && ((32'(fillCnt) + 32'd1) >= fullCnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curM    <= '0;
      fillCnt <= '0;
    end else if (strobe.clear) begin
      curM    <= lenSel;
      fillCnt <= '0;
    end else if (strobe.accept && (32'(fillCnt) < fullCnt)) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(lenSel) <= MAX_M);
  p_follow_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> (curM == $past(lenSel) && fillCnt == '0));
  p_fill_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fillCnt) <= fullCnt);
  p_emit_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.emit |=> (32'(fillCnt) == fullCnt));
endmodule

// File: rtl/trif_datapath.sv
module trif_datapath
  import trif_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_M  = 7,
  parameter int M_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  trifStrobe_t              strobe,
  input  logic [M_W-1:0]           curM,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] filtOut,
  output logic                     filtValid
);
  localparam int STAGES = 2;

  logic [STAGES:0][DATA_W-1:0] chain;

  assign chain[0] = sampleIn;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic signed [DATA_W-1:0] stageOut;
    trif_boxcar #(.DATA_W(DATA_W), .MAX_M(MAX_M), .M_W(M_W)) u_box (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobe),
      .shiftM (curM),
      .dIn    ($signed(chain[g])),
      .avgOut (stageOut)
    );
    assign chain[g+1] = stageOut;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear) begin
      filtOut   <= '0;
      filtValid <= 1'b0;
    end else begin
      filtValid <= strobe.emit;
      if (strobe.accept) filtOut <= $signed(chain[STAGES]);
    end
  end

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.accept && !strobe.clear) |=> ($stable(filtOut) && !filtValid));
  p_clear_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> (filtOut == '0 && !filtValid));
endmodule

// File: rtl/tri_window_filter.sv
module tri_window_filter
  import trif_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_M  = 7,
  parameter int M_W    = $clog2(MAX_M + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic [M_W-1:0]           lenSel,
  output logic signed [DATA_W-1:0] filtOut,
  output logic                     filtValid
);
  trifStrobe_t    strobe;
  logic [M_W-1:0] curM;

  trif_ctrl #(.MAX_M(MAX_M), .M_W(M_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sampleValid (sampleValid),
    .lenSel      (lenSel),
    .strobe      (strobe),
    .curM        (curM)
  );

  trif_datapath #(.DATA_W(DATA_W), .MAX_M(MAX_M), .M_W(M_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .curM      (curM),
    .sampleIn  (sampleIn),
    .filtOut   (filtOut),
    .filtValid (filtValid)
  );

  p_valid_after_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    filtValid |-> $past(sampleValid));
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (filtOut == '0 && !filtValid));
endmodule

// File: tb/tb_tri_window_filter.sv
module tb_tri_window_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic [2:0] lenSel = '0;
  logic signed [15:0] filtOut;
  logic filtValid;

  always #2 clk = ~clk;

  tri_window_filter dut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .lenSel(lenSel), .filtOut(filtOut), .filtValid(filtValid)
  );

  int total = 0;
  int bad = 0;
  int xh [512];
  int ah [512];
  int k = 0;
  int curM = 0;
  int lastY = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelStep(int x, output int y, output bit v);
    longint s;
    longint s2;
    int n;
    n = 1 << curM;
    xh[k] = x;
    s = 0;
    for (int j = 0; j < n; j++) if (k - j >= 0) s += xh[k-j];
    ah[k] = int'(s >>> curM);
    s2 = 0;
    for (int j = 0; j < n; j++) if (k - j >= 0) s2 += ah[k-j];
    y = int'(s2 >>> curM);
    k++;
    v = (k >= 2*n - 1);
  endtask

  task automatic sendSample(int x, string tag);
    int y;
    bit v;
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = 16'(x);
    @(posedge clk);
    #1;
    modelStep(x, y, v);
    lastY = y;
    check(int'(filtOut) == y, tag, int'(filtOut), y);
    check(filtValid == v, {tag, "/R4"}, filtValid, v);
  endtask

  task automatic idle(int cycles);
    logic signed [15:0] held;
    @(negedge clk);
    sampleValid = 1'b0;
    held = filtOut;
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      #1;
      check(filtOut == held && !filtValid, "R8 hold", int'(filtOut), int'(held));
    end
  endtask

  task automatic setLen(int m);
    @(negedge clk);
    sampleValid = 1'b0;
    lenSel = 3'(m);
    @(posedge clk);
    #1;
    check(filtOut == 0 && !filtValid, "R5 clear", int'(filtOut), 0);
    curM = m;
    k = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nz;
    int peak;
    repeat (3) @(posedge clk);
    #1;
    check(filtOut == 0 && !filtValid, "R1 reset", int'(filtOut), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(filtOut == 0 && !filtValid, "R1 after reset", int'(filtOut), 0);

    // Sweep every length with random data and random gaps.
    for (int m = 0; m < 8; m++) begin
      setLen(m);
      for (int s = 0; s < 2*(1 << m) + 12; s++) begin
        sendSample(int'($urandom_range(0, 65535)) - 32768, (m == 0) ? "R6 pass" : "R3 tri");
        if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 2)));
      end
    end

    // R2: impulse at M=3 gives a 15-long triangle peaking at 4000.
    setLen(2);
    setLen(3);
    nz = 0;
    peak = 0;
    sendSample(32000, "R2 impulse");
    if (lastY != 0) nz++;
    for (int s = 0; s < 19; s++) begin
      sendSample(0, "R2 impulse");
      if (lastY != 0) nz++;
      if (lastY > peak) peak = lastY;
    end
    check(nz == 15, "R2 span", nz, 15);
    check(peak == 4000, "R2 peak", peak, 4000);

    // R5: length change together with a strobe drops that sample.
    for (int s = 0; s < 10; s++) sendSample(100 * s - 300, "R3 pre-change");
    @(negedge clk);
    lenSel = 3'd2;
    sampleValid = 1'b1;
    sampleIn = 16'sd1234;
    @(posedge clk);
    #1;
    check(filtOut == 0 && !filtValid, "R5 drop", int'(filtOut), 0);
    curM = 2;
    k = 0;
    for (int s = 0; s < 10; s++) sendSample(50 * s + 7, "R5 after drop");

    // R7: full-scale constants at the longest window.
    setLen(6);
    setLen(7);
    for (int s = 0; s < 260; s++) sendSample(32767, "R7 max");
    check(int'(filtOut) == 32767 && filtValid, "R7 max end", int'(filtOut), 32767);
    setLen(6);
    setLen(7);
    for (int s = 0; s < 260; s++) sendSample(-32768, "R7 min");
    check(int'(filtOut) == -32768 && filtValid, "R7 min end", int'(filtOut), -32768);

    // R9: floor on negative values.
    setLen(1);
    sendSample(-1, "R9 floor");
    check(int'(filtOut) == -1, "R9 value", int'(filtOut), -1);
    sendSample(0, "R9 floor");
    sendSample(3, "R9 floor");
    idle(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule